// File: doc/BRIEF.md
# Resampler Rate Generator with Leap Correction and Fill Gate

This block produces the timing for a fractional resampler. A first 48-bit phase accumulator advances by a tuning word on every clock, and its wrap produces the output-rate strobe. A second 48-bit accumulator advances by its own tuning word only on those strobes. Its wraps request a new input sample, and its upper bits give the resampler the interpolation phase. A 32-bit leap timer reloads both accumulators at a programmed interval, which removes the drift that finite word length causes.

An 8-entry sample FIFO sits between the upstream writer and the resampler. It absorbs the jitter of the strobes. After reset, both accumulators stay idle until the FIFO holds two samples. Reads begin only once a further 0 to 3 samples have arrived. That extra depth is captured once, after reset. Until reads begin, the data handed to the resampler is zero. The interpolation filter arithmetic is not part of this block.

Top module: `rs_rate_gen`

## Requirements
- R1: `out_stb_o` is a one-clock pulse for each clock on which the first 48-bit accumulator wraps while adding `out_step_i`. With a step of 2^47, it pulses on exactly every second clock.
- R2: The second accumulator advances by `in_step_i` only in the cycle after an `out_stb_o` pulse. `in_stb_o` pulses on its wraps and is never high unless `out_stb_o` was high in the previous cycle.
- R3: `res_phase_o` is the top 8 bits of the second accumulator. While that accumulator is idle, it is loaded with `phase_ofs_i[7:0]` placed in those top bits.
- R4: When `phase_ofs_i[8]` is 1, the first wrap of the second accumulator after each load is suppressed. This delays input strobes by one whole input period.
- R5: When `leap_int_i` is nonzero, a leap event occurs once every `leap_int_i` clocks while running. On that clock, the first accumulator is reloaded to zero and the second is reloaded to its offset, instead of stepping. A value of 0 disables leap events.
- R6: `out_stb_o` stays low until the FIFO has held two samples since reset.
- R7: Reads are enabled once FIFO occupancy reaches 2 plus the extra depth. The extra depth is taken from `extra_depth_i` on the first clock after reset release, and later changes to it are ignored.
- R8: `rd_data_o` is zero until reads are enabled. After that, each read loads the oldest sample, so samples come out in write order.
- R9: A read is attempted on each `in_stb_o` when `half_band_i` is 0. When it is 1, a read is attempted on every second `in_stb_o`, starting with the first. `rd_stb_o` marks each read attempted while reads are enabled.
- R10: A write while the FIFO holds 8 samples is dropped and sets `ovf_o`, which stays set until reset.
- R11: A read attempted with the FIFO empty sets `unf_o`, which stays set until reset, and drives `rd_data_o` to zero.
- R12: During and after reset, `out_stb_o`, `in_stb_o`, `rd_stb_o`, `rd_data_o`, `ovf_o` and `unf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_step_i | input | 48 | Tuning word of the output-rate accumulator |
| in_step_i | input | 48 | Tuning word of the input-rate accumulator |
| phase_ofs_i | input | 9 | Static offset of the second accumulator, in 1/256 input periods |
| leap_int_i | input | 32 | Leap interval in clocks, 0 disables |
| extra_depth_i | input | 2 | Additional fill before reads, captured after reset |
| half_band_i | input | 1 | Read on every second input strobe |
| wr_en_i | input | 1 | Write a sample into the FIFO |
| wr_data_i | input | 16 | Sample to write |
| out_stb_o | output | 1 | Output-rate strobe |
| in_stb_o | output | 1 | Input-request strobe |
| rd_stb_o | output | 1 | FIFO read performed this cycle |
| res_phase_o | output | 8 | Resampler phase |
| rd_data_o | output | 16 | Sample passed to the resampler |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |

## Verification
The hardest situation to reach from the ports is the window between the start of the accumulators and the start of reads. During that window, input strobes already occur, yet the data must stay zero and must not count as underflow. The stimulus latches an extra depth of two and writes only two samples. It then waits while input strobes run, and only afterwards writes the rest and checks the read order. The one-period offset bit and the leap reload are made visible in the same indirect way. The bench compares the delay to the first input strobe and the strobe count over a long window against values computed from the tuning words.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned ACC_W      = 48;
  localparam int unsigned LEAP_W     = 32;
  localparam int unsigned OFS_W      = 9;
  localparam int unsigned PH_W       = OFS_W - 1;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned MIN_FILL   = 2;
  localparam int unsigned XD_W       = 2;
endpackage

// File: rtl/rs_rate_acc.sv
module rs_rate_acc #(
  parameter int unsigned W     = 48,
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic             adv_i,
  input  logic [W-1:0]     step_i,
  output logic             carry_o,
  output logic [OUT_W-1:0] phase_o
);
  logic [W-1:0] acc_q;
  logic         carry_q;
  logic [W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (load_i) begin
      acc_q   <= load_val_i;
      carry_q <= 1'b0;
    end else if (adv_i) begin
      acc_q   <= sum[W-1:0];
      carry_q <= sum[W];
    end else begin
      carry_q <= 1'b0;
    end
  end

  assign carry_o = carry_q;
  assign phase_o = acc_q[W-1 -: OUT_W];

  // R5: a reload never produces a wrap pulse
  a_r5_load_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !carry_o);
  // R2: phase only moves when stepped or reloaded
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(acc_q) && !carry_o));
endmodule

// File: rtl/rs_leap_timer.sv
module rs_leap_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] interval_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = run_i && (interval_i != '0) && (cnt_q >= interval_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || hit_o)         cnt_q <= '0;
    else if (interval_i != '0)        cnt_q <= cnt_q + W'(1);
  end

  // R5: back-to-back events only for an interval of one
  a_r5_leap_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && interval_i > W'(1) && $stable(interval_i)) |=> !hit_o);
endmodule

// File: rtl/rs_sample_fifo.sv
module rs_sample_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_push, do_pop;
  logic          ovf_q, unf_q;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (do_push) wptr_q <= wptr_q + AW'(1);
      if (do_pop)  rptr_q <= rptr_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      if (push_i && full) ovf_q <= 1'b1;
      if (pop_i && empty) unf_q <= 1'b1;
    end
  end

  assign head_o = mem_q[rptr_q];
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_o |=> ovf_o);
  a_r11_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) unf_o |=> unf_o);
  a_r10_cnt_bound:  assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_o <= CW'(DEPTH));
endmodule

// File: rtl/rs_rate_gen.sv
module rs_rate_gen
  import rs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  out_step_i,
  input  logic [ACC_W-1:0]  in_step_i,
  input  logic [OFS_W-1:0]  phase_ofs_i,
  input  logic [LEAP_W-1:0] leap_int_i,
  input  logic [XD_W-1:0]   extra_depth_i,
  input  logic              half_band_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              out_stb_o,
  output logic              in_stb_o,
  output logic              rd_stb_o,
  output logic [PH_W-1:0]   res_phase_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int unsigned CW    = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned ZPAD  = ACC_W - PH_W;

  logic              cfg_done_q, run_q, rd_on_q, skip_q, tgl_q;
  logic [XD_W-1:0]   extra_q;
  logic [CW-1:0]     cnt, rd_thr;
  logic [DATA_W-1:0] head, rd_q;
  logic              leap_hit, acc_load, carry2, in_stb, rd_tick, pop;
  logic [PH_W-1:0]   ph1;
  logic [ACC_W-1:0]  ofs_val;

  assign rd_thr   = CW'(MIN_FILL) + CW'(extra_q);
  assign acc_load = !run_q || leap_hit;
  assign ofs_val  = {phase_ofs_i[PH_W-1:0], {ZPAD{1'b0}}};

  // config capture and start gating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_q <= 1'b0;
      extra_q    <= '0;
      run_q      <= 1'b0;
      rd_on_q    <= 1'b0;
    end else begin
      if (!cfg_done_q) begin
        cfg_done_q <= 1'b1;
        extra_q    <= extra_depth_i;
      end
      if (cfg_done_q && cnt >= CW'(MIN_FILL)) run_q   <= 1'b1;
      if (run_q && cnt >= rd_thr)              rd_on_q <= 1'b1;
    end
  end

  rs_leap_timer #(.W(LEAP_W)) u_leap (
    .clk_i, .rst_ni, .run_i(run_q), .interval_i(leap_int_i), .hit_o(leap_hit)
  );

  rs_rate_acc #(.W(ACC_W), .OUT_W(PH_W)) u_acc_out (
    .clk_i, .rst_ni, .load_i(acc_load), .load_val_i('0), .adv_i(1'b1),
    .step_i(out_step_i), .carry_o(out_stb_o), .phase_o(ph1)
  );

  rs_rate_acc #(.W(ACC_W), .OUT_W(PH_W)) u_acc_in (
    .clk_i, .rst_ni, .load_i(acc_load), .load_val_i(ofs_val), .adv_i(out_stb_o),
    .step_i(in_step_i), .carry_o(carry2), .phase_o(res_phase_o)
  );

  // whole-period offset swallows the first wrap after a load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       skip_q <= 1'b0;
    else if (acc_load) skip_q <= phase_ofs_i[OFS_W-1];
    else if (carry2)   skip_q <= 1'b0;
  end

  assign in_stb = carry2 && !skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgl_q <= 1'b0;
    else if (in_stb) tgl_q <= ~tgl_q;
  end

  assign rd_tick = in_stb && (!half_band_i || !tgl_q);
  assign pop     = rd_tick && rd_on_q;

  rs_sample_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(wr_en_i), .data_i(wr_data_i), .pop_i(pop),
    .head_o(head), .cnt_o(cnt), .ovf_o, .unf_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_q <= '0;
    else if (pop) rd_q <= (cnt == '0) ? '0 : head;
  end

  assign in_stb_o  = in_stb;
  assign rd_stb_o  = pop;
  assign rd_data_o = rd_q;

  a_r6_idle_no_stb:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !out_stb_o);
  a_r2_in_follows_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stb_o |-> $past(out_stb_o));
  a_r8_zero_pre_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_on_q |-> (rd_data_o == '0));
  a_r7_extra_frozen:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_q |=> $stable(extra_q));
  a_r5_leap_zero_ph:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    leap_hit |=> (ph1 == '0));
  a_r9_hb_alternate:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_band_i && rd_stb_o) |-> !tgl_q);
endmodule

// File: tb/tb_rs_rate_gen.sv
module tb_rs_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] out_step = '0, in_step = '0;
  logic [8:0]  ofs = '0;
  logic [31:0] leap = '0;
  logic [1:0]  xd = '0;
  logic        hb = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        out_stb, in_stb, rd_stb, ovf, unf;
  logic [7:0]  res_phase;
  logic [15:0] rd_data;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  rs_rate_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .out_step_i(out_step), .in_step_i(in_step),
    .phase_ofs_i(ofs), .leap_int_i(leap), .extra_depth_i(xd), .half_band_i(hb),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .out_stb_o(out_stb), .in_stb_o(in_stb),
    .rd_stb_o(rd_stb), .res_phase_o(res_phase), .rd_data_o(rd_data),
    .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_cnt(input int n, output int o, output int i, output int r);
    o = 0; i = 0; r = 0;
    repeat (n) begin
      @(negedge clk);
      o += int'(out_stb); i += int'(in_stb); r += int'(rd_stb);
    end
  endtask

  task automatic t_reset_phase();
    int o, i, r;
    ofs = 9'h080; out_step = 48'h8000_0000_0000; in_step = 48'h4000_0000_0000;
    leap = 0; xd = 0; hb = 0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(out_stb == 0 && in_stb == 0 && rd_stb == 0 && rd_data == 0 && ovf == 0 && unf == 0,
        "R12 reset outputs", {out_stb, in_stb, rd_stb, ovf, unf}, 0);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    run_cnt(3, o, i, r);
    chk(res_phase == 8'h80, "R3 idle phase offset", res_phase, 8'h80);
    push(1); push(2);
    while (!out_stb) @(negedge clk);
    @(negedge clk);
    chk(res_phase == 8'hC0, "R3 phase after one step", res_phase, 8'hC0);
  endtask

  task automatic t_rates();
    int o, i, r;
    ofs = 0; out_step = 48'h8000_0000_0000; in_step = 48'h8000_0000_0000;
    do_reset();
    push(1);
    run_cnt(20, o, i, r);
    chk(o == 0, "R6 no strobe with one sample", o, 0);
    push(2);
    run_cnt(6, o, i, r);
    run_cnt(40, o, i, r);
    chk(o == 20, "R1 out strobe every second clock", o, 20);
    run_cnt(80, o, i, r);
    chk(i == 20, "R2 in strobe every second out strobe", i, 20);
  endtask

  task automatic first_in_delay(input logic [8:0] v, output int k);
    ofs = v; out_step = 48'h8000_0000_0000; in_step = 48'h8000_0000_0000;
    do_reset();
    push(1); push(2);
    k = 0;
    while (!in_stb && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic t_offset();
    int d0, d1;
    first_in_delay(9'h000, d0);
    first_in_delay(9'h100, d1);
    chk(d1 - d0 == 4, "R4 whole-period offset delay", d1 - d0, 4);
  endtask

  task automatic t_leap();
    int o, i, r;
    ofs = 0; out_step = 48'h7FFF_FFFF_FFFF; in_step = 0; leap = 4;
    do_reset();
    push(1); push(2);
    run_cnt(20, o, i, r);
    run_cnt(400, o, i, r);
    chk(o >= 99 && o <= 101, "R5 leap every 4 clocks", o, 100);
    leap = 0;
    run_cnt(8, o, i, r);
    run_cnt(400, o, i, r);
    chk(o >= 199 && o <= 201, "R5 leap disabled", o, 200);
  endtask

  task automatic t_depth();
    int o, i, r, n;
    logic [15:0] last;
    logic [15:0] got [4];
    ofs = 0; out_step = 48'h8000_0000_0000; in_step = 48'h8000_0000_0000; leap = 0;
    xd = 2;
    do_reset();
    push(16'h0001); push(16'h0002);
    run_cnt(30, o, i, r);
    chk(i > 0, "R7 strobes run before reads", i, 1);
    chk(rd_data == 0 && r == 0, "R8 zero data before depth", rd_data, 0);
    chk(unf == 0, "R11 no underflow before reads", unf, 0);
    push(16'h0003); push(16'h0004);
    n = 0; last = 0;
    for (int c = 0; c < 60 && n < 4; c++) begin
      @(negedge clk);
      if (rd_data != 0 && rd_data != last) begin got[n] = rd_data; n++; end
      last = rd_data;
    end
    for (int j = 0; j < 4; j++)
      chk(j < n && got[j] == 16'(j + 1), "R8 read order", (j < n) ? got[j] : -1, j + 1);
  endtask

  task automatic t_latch();
    bit seen;
    xd = 0; out_step = 48'h8000_0000_0000; in_step = 48'h8000_0000_0000;
    do_reset();
    @(negedge clk); xd = 3;
    push(16'h0001); push(16'h0002);
    seen = 0;
    repeat (40) begin @(negedge clk); if (rd_data == 16'h0001) seen = 1; end
    chk(seen, "R7 extra depth latched after reset", seen, 1);
    xd = 0;
  endtask

  task automatic t_half_band();
    int o, i, r;
    hb = 1; out_step = 48'h8000_0000_0000; in_step = 48'h8000_0000_0000;
    do_reset();
    for (int k = 1; k <= 8; k++) push(16'(k));
    run_cnt(80, o, i, r);
    chk(i == 20, "R9 in strobes with half band", i, 20);
    chk(r * 2 == i, "R9 reads every second strobe", r, i / 2);
    hb = 0;
  endtask

  task automatic t_underflow();
    int o, i, r;
    out_step = 48'h8000_0000_0000; in_step = 48'h8000_0000_0000;
    do_reset();
    push(5); push(6);
    run_cnt(100, o, i, r);
    chk(unf == 1, "R11 underflow sticky", unf, 1);
    chk(rd_data == 0, "R11 zero data on underflow", rd_data, 0);
    chk(ovf == 0, "R10 no overflow", ovf, 0);
  endtask

  task automatic t_overflow();
    int o, i, r;
    out_step = 0; in_step = 0;
    do_reset();
    for (int k = 1; k <= 8; k++) push(16'(k));
    chk(ovf == 0, "R10 eight samples fit", ovf, 0);
    push(9);
    run_cnt(10, o, i, r);
    chk(ovf == 1, "R10 overflow sticky", ovf, 1);
    chk(unf == 0, "R11 no underflow without reads", unf, 0);
    do_reset();
    @(negedge clk);
    chk(ovf == 0, "R12 reset clears overflow", ovf, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_phase();
    t_rates();
    t_offset();
    t_leap();
    t_depth();
    t_latch();
    t_half_band();
    t_underflow();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule